// File: doc/BRIEF.md
# Two-Level Page Walker

This block resolves a 32-bit linear address into a physical page after a miss in a translation cache. It serves a 32-bit, non-extended paging scheme with two levels: a directory word and a table word, or a single directory word for a 4 MB region. A request carries the linear address, a write flag, a user flag and a paging-enabled flag. At the same moment the block takes the directory base (CR3), the supervisor write-protect bit (CR0.WP), the large-page enable (CR4.PSE) and the A20 address mask. All of these are latched when the request is accepted.

The walker reads entries over a memory port that has one access outstanding at a time, using a req/ack handshake. It sets the accessed bit, and on a write the dirty bit, in the entries it walks through. It then signals completion with a one-cycle `done` pulse. That pulse carries either a 4 KB physical frame with its write permission and a large-page flag, or a fault code with the faulting linear address. Write permission is granted only for a leaf that is dirty at the end of the walk. A read of a clean page therefore produces a read-only result, and the first write to it walks again and marks the page.

Entry bit positions: present = bit 0, read/write = bit 1, user = bit 2, accessed = bit 5, dirty = bit 6, page size = bit 7.

Top module: `ptw_walker`

## Requirements
- R1: With the paging-enabled flag clear, the result is the linear address with bits 11:0 cleared and ANDed with the A20 mask. It has no fault, write permission is set, the large-page flag is clear, and the block performs no memory access.
- R2: The first read goes to the address formed as (CR3 with bits 11:0 cleared) + 4 × linear[31:22], ANDed with the A20 mask.
- R3: A second-level read goes to the address formed as (directory word with bits 11:0 cleared) + 4 × linear[21:12], ANDed with the A20 mask.
- R4: A present directory word with bit 7 set ends the walk as a 4 MB page only when CR4.PSE is 1. In that case the result is directory[31:22] joined with linear[21:12], and the large-page flag is set. When CR4.PSE is 0 the walk goes on to the second level.
- R5: A present bit that is clear in either entry ends the walk with a fault whose code bit 0 is 0. When the directory word is absent, no second-level read is made.
- R6: The effective user and read/write rights are the directory bits for a 4 MB page and the AND of both entries for a 4 KB page. A user access needs user = 1, and a user write also needs read/write = 1. A supervisor write needs read/write = 1 only when CR0.WP is 1. A rights failure faults with code bit 0 = 1.
- R7: A fault code has bit 1 equal to the write flag and bit 2 equal to the user flag. The reported fault address (CR2 value) is the full linear address.
- R8: Every entry that is walked and lacks bit 5 is written back with bit 5 set. An entry that needs no change is not written. On a 4 KB walk, the directory write-back comes before the second-level read.
- R9: On a write, the leaf entry (the table word, or the directory word of a 4 MB page) is written back with bit 6 set if that bit was clear.
- R10: The result allows writes only when the leaf is dirty after the walk and the rights permit a write: read/write = 1 for user, or read/write = 1 or CR0.WP = 0 for supervisor.
- R11: Every returned physical frame is ANDed with the latched A20 mask and has bits 11:0 equal to zero.
- R12: `req_ready` is high only while idle, and a request seen while busy is ignored. The memory request, address and direction stay stable until `mem_ack`. `done` lasts exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request taken on this edge |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is at user privilege |
| req_pg_en | input | 1 | Paging enabled |
| cr3 | input | 32 | Directory base |
| cr0_wp | input | 1 | Supervisor write protect |
| cr4_pse | input | 1 | 4 MB page enable |
| a20_mask | input | 32 | Physical address mask |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write-back entry value |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| done | output | 1 | One-cycle completion pulse |
| res_fault | output | 1 | Walk ended in a fault |
| res_ecode | output | 3 | Fault code {user, write, protection} |
| res_cr2 | output | 32 | Faulting linear address |
| res_paddr | output | 32 | 4 KB physical frame |
| res_wr | output | 1 | Result allows writes |
| res_big | output | 1 | Result came from a 4 MB page |

## Verification
The hardest case to reach from the ports is the sequence of memory traffic inside a single walk. This covers the directory write-back that must land before the second-level read, write-backs that must be absent on an entry already marked, and requests that arrive mid-walk and must not start a second walk. The memory model records every access of a walk, in order, with its direction, address and written value. A table image seeded with clean, unaccessed entries is walked again and again, so that the same words pass from clean to accessed to dirty. Memory latency changes from walk to walk, and one walk gets extra request pulses while the first directory read is still waiting for its acknowledge.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int LA_W    = 32;
    localparam int OFS_W   = 12;
    localparam int IDX_W   = 10;
    localparam int EC_W    = 3;
    localparam int ENT_SH  = 2;
    localparam int BIG_SH  = OFS_W + IDX_W;

    localparam int B_P  = 0;
    localparam int B_RW = 1;
    localparam int B_US = 2;
    localparam int B_A  = 5;
    localparam int B_D  = 6;
    localparam int B_PS = 7;

    localparam int EC_PROT = 0;
    localparam int EC_WR   = 1;
    localparam int EC_USR  = 2;

    typedef logic [LA_W-1:0] word_t;

    localparam word_t OFS_MASK = word_t'((64'd1 << OFS_W) - 64'd1);
    localparam word_t BIG_MASK = ~word_t'((64'd1 << BIG_SH) - 64'd1);
    localparam word_t MID_MASK = ~BIG_MASK & ~OFS_MASK;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_DIR,
        S_CHK_DIR,
        S_WB_DIR,
        S_RD_TBL,
        S_CHK_TBL,
        S_WB_TBL,
        S_FIN
    } wstate_e;

    typedef struct packed {
        logic            fault;
        logic [EC_W-1:0] ecode;
        word_t           cr2;
        word_t           paddr;
        logic            wr;
        logic            big;
    } result_t;

    function automatic word_t small_frame(word_t ent, word_t a20);
        return ent & ~OFS_MASK & a20;
    endfunction

    function automatic word_t large_frame(word_t ent, word_t lin, word_t a20);
        return ((ent & BIG_MASK) | (lin & MID_MASK)) & a20;
    endfunction

    function automatic word_t touch(word_t ent, logic set_dirty);
        word_t v;
        v = ent;
        v[B_A] = 1'b1;
        if (set_dirty) v[B_D] = 1'b1;
        return v;
    endfunction

    function automatic result_t fault_res(word_t lin, logic usr, logic wr, logic prot);
        result_t r;
        r = '0;
        r.fault = 1'b1;
        r.ecode[EC_PROT] = prot;
        r.ecode[EC_WR]   = wr;
        r.ecode[EC_USR]  = usr;
        r.cr2 = lin;
        return r;
    endfunction

    function automatic result_t ok_res(word_t lin, word_t pa, logic wr, logic big);
        result_t r;
        r = '0;
        r.cr2   = lin;
        r.paddr = pa;
        r.wr    = wr;
        r.big   = big;
        return r;
    endfunction

endpackage

// File: rtl/ptw_addr.sv
module ptw_addr
    import ptw_pkg::*;
(
    input  word_t             base,
    input  logic [IDX_W-1:0]  idx,
    input  word_t             a20,
    output word_t             eaddr
);
    word_t base_al;
    word_t offs;

    assign base_al = base & ~OFS_MASK;
    assign offs    = word_t'({idx, {ENT_SH{1'b0}}});
    assign eaddr   = (base_al + offs) & a20;
endmodule

// File: rtl/ptw_rights.sv
module ptw_rights (
    input  logic eff_us,
    input  logic eff_rw,
    input  logic leaf_dirty,
    input  logic acc_write,
    input  logic acc_user,
    input  logic wp,
    output logic deny,
    output logic grant_w
);
    always_comb begin
        if (acc_user) begin
            deny    = !eff_us || (acc_write && !eff_rw);
            grant_w = leaf_dirty && eff_rw;
        end else begin
            deny    = wp && acc_write && !eff_rw;
            grant_w = leaf_dirty && (eff_rw || !wp);
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [LA_W-1:0]  req_lin,
    input  logic             req_write,
    input  logic             req_user,
    input  logic             req_pg_en,
    input  logic [LA_W-1:0]  cr3,
    input  logic             cr0_wp,
    input  logic             cr4_pse,
    input  logic [LA_W-1:0]  a20_mask,
    output logic             mem_req,
    output logic             mem_we,
    output logic [LA_W-1:0]  mem_addr,
    output logic [LA_W-1:0]  mem_wdata,
    input  logic             mem_ack,
    input  logic [LA_W-1:0]  mem_rdata,
    output logic             done,
    output logic             res_fault,
    output logic [EC_W-1:0]  res_ecode,
    output logic [LA_W-1:0]  res_cr2,
    output logic [LA_W-1:0]  res_paddr,
    output logic             res_wr,
    output logic             res_big
);
    wstate_e st;
    word_t   lin_q, cr3_q, a20_q, pde_q, pte_q;
    logic    w_q, u_q, wp_q, pse_q;
    result_t res_q;

    word_t   dir_addr, tbl_addr;
    word_t   pde_upd, pte_upd;
    logic    is_big, leaf_sel;
    logic    eff_us, eff_rw, leaf_dirty;
    logic    deny, grant_w;

    ptw_addr u_dir_addr (
        .base  (cr3_q),
        .idx   (lin_q[LA_W-1:BIG_SH]),
        .a20   (a20_q),
        .eaddr (dir_addr)
    );

    ptw_addr u_tbl_addr (
        .base  (pde_q),
        .idx   (lin_q[BIG_SH-1:OFS_W]),
        .a20   (a20_q),
        .eaddr (tbl_addr)
    );

    assign is_big   = pde_q[B_PS] && pse_q;
    assign pde_upd  = touch(pde_q, is_big && w_q);
    assign pte_upd  = touch(pte_q, w_q);
    assign leaf_sel = (st == S_CHK_TBL);

    always_comb begin
        if (leaf_sel) begin
            eff_us     = pde_q[B_US] & pte_q[B_US];
            eff_rw     = pde_q[B_RW] & pte_q[B_RW];
            leaf_dirty = pte_upd[B_D];
        end else begin
            eff_us     = pde_q[B_US];
            eff_rw     = pde_q[B_RW];
            leaf_dirty = pde_upd[B_D];
        end
    end

    ptw_rights u_rights (
        .eff_us     (eff_us),
        .eff_rw     (eff_rw),
        .leaf_dirty (leaf_dirty),
        .acc_write  (w_q),
        .acc_user   (u_q),
        .wp         (wp_q),
        .deny       (deny),
        .grant_w    (grant_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            lin_q <= '0;
            cr3_q <= '0;
            a20_q <= '0;
            pde_q <= '0;
            pte_q <= '0;
            w_q   <= 1'b0;
            u_q   <= 1'b0;
            wp_q  <= 1'b0;
            pse_q <= 1'b0;
            res_q <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        lin_q <= req_lin;
                        cr3_q <= cr3;
                        a20_q <= a20_mask;
                        w_q   <= req_write;
                        u_q   <= req_user;
                        wp_q  <= cr0_wp;
                        pse_q <= cr4_pse;
                        if (req_pg_en) begin
                            st <= S_RD_DIR;
                        end else begin
                            res_q <= ok_res(req_lin, small_frame(req_lin, a20_mask), 1'b1, 1'b0);
                            st    <= S_FIN;
                        end
                    end
                end
                S_RD_DIR: begin
                    if (mem_ack) begin
                        pde_q <= mem_rdata;
                        st    <= S_CHK_DIR;
                    end
                end
                S_CHK_DIR: begin
                    if (!pde_q[B_P]) begin
                        res_q <= fault_res(lin_q, u_q, w_q, 1'b0);
                        st    <= S_FIN;
                    end else if (is_big) begin
                        if (deny) begin
                            res_q <= fault_res(lin_q, u_q, w_q, 1'b1);
                            st    <= S_FIN;
                        end else begin
                            res_q <= ok_res(lin_q, large_frame(pde_q, lin_q, a20_q), grant_w, 1'b1);
                            st    <= (pde_upd != pde_q) ? S_WB_DIR : S_FIN;
                        end
                    end else begin
                        st <= pde_q[B_A] ? S_RD_TBL : S_WB_DIR;
                    end
                end
                S_WB_DIR: begin
                    if (mem_ack) st <= is_big ? S_FIN : S_RD_TBL;
                end
                S_RD_TBL: begin
                    if (mem_ack) begin
                        pte_q <= mem_rdata;
                        st    <= S_CHK_TBL;
                    end
                end
                S_CHK_TBL: begin
                    if (!pte_q[B_P]) begin
                        res_q <= fault_res(lin_q, u_q, w_q, 1'b0);
                        st    <= S_FIN;
                    end else if (deny) begin
                        res_q <= fault_res(lin_q, u_q, w_q, 1'b1);
                        st    <= S_FIN;
                    end else begin
                        res_q <= ok_res(lin_q, small_frame(pte_q, a20_q), grant_w, 1'b0);
                        st    <= (pte_upd != pte_q) ? S_WB_TBL : S_FIN;
                    end
                end
                S_WB_TBL: begin
                    if (mem_ack) st <= S_FIN;
                end
                S_FIN: begin
                    st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign req_ready = (st == S_IDLE);
    assign done      = (st == S_FIN);
    assign mem_req   = (st == S_RD_DIR) || (st == S_WB_DIR) ||
                       (st == S_RD_TBL) || (st == S_WB_TBL);
    assign mem_we    = (st == S_WB_DIR) || (st == S_WB_TBL);
    assign mem_addr  = ((st == S_RD_DIR) || (st == S_WB_DIR)) ? dir_addr : tbl_addr;
    assign mem_wdata = (st == S_WB_DIR) ? pde_upd : pte_upd;

    assign res_fault = res_q.fault;
    assign res_ecode = res_q.ecode;
    assign res_cr2   = res_q.cr2;
    assign res_paddr = res_q.paddr;
    assign res_wr    = res_q.wr;
    assign res_big   = res_q.big;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
    import ptw_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_pg_en,
    input logic        req_write,
    input logic        req_user,
    input word_t       req_lin,
    input word_t       a20_mask,
    input logic        mem_req,
    input logic        mem_ack,
    input logic        mem_we,
    input word_t       mem_addr,
    input logic        wb_a_bit,
    input logic        done,
    input logic        res_fault,
    input logic [1:0]  res_ecode_hi,
    input word_t       res_cr2,
    input word_t       res_paddr,
    input logic        res_wr,
    input logic        res_big
);
    logic  chk_w, chk_u, flat_walk;
    word_t chk_lin, chk_a20;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_w     <= 1'b0;
            chk_u     <= 1'b0;
            chk_lin   <= '0;
            chk_a20   <= '1;
            flat_walk <= 1'b0;
        end else if (req_valid && req_ready) begin
            chk_w     <= req_write;
            chk_u     <= req_user;
            chk_lin   <= req_lin;
            chk_a20   <= a20_mask;
            flat_walk <= !req_pg_en;
        end else if (done) begin
            flat_walk <= 1'b0;
        end
    end

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_no_accept_busy_R12: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);

    assert_flat_no_mem_R1: assert property (@(posedge clk) disable iff (rst)
        flat_walk |-> !mem_req);

    assert_flat_result_R1: assert property (@(posedge clk) disable iff (rst)
        (done && flat_walk) |-> (!res_fault && res_wr && !res_big));

    assert_fault_code_R7: assert property (@(posedge clk) disable iff (rst)
        (done && res_fault) |-> (res_ecode_hi == {chk_u, chk_w} && res_cr2 == chk_lin));

    assert_frame_masked_R11: assert property (@(posedge clk) disable iff (rst)
        (done && !res_fault) |-> ((res_paddr & ~chk_a20) == '0 && (res_paddr & OFS_MASK) == '0));

    assert_wb_sets_acc_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> wb_a_bit);
endmodule

bind ptw_walker ptw_walker_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_pg_en    (req_pg_en),
    .req_write    (req_write),
    .req_user     (req_user),
    .req_lin      (req_lin),
    .a20_mask     (a20_mask),
    .mem_req      (mem_req),
    .mem_ack      (mem_ack),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .wb_a_bit     (mem_wdata[5]),
    .done         (done),
    .res_fault    (res_fault),
    .res_ecode_hi (res_ecode[2:1]),
    .res_cr2      (res_cr2),
    .res_paddr    (res_paddr),
    .res_wr       (res_wr),
    .res_big      (res_big)
);

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        req_pg_en = 1'b0;
    logic [31:0] cr3 = '0;
    logic        cr0_wp = 1'b0;
    logic        cr4_pse = 1'b0;
    logic [31:0] a20_mask = '1;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done, res_fault, res_wr, res_big;
    logic [2:0]  res_ecode;
    logic [31:0] res_cr2, res_paddr;

    always #2 clk = ~clk;

    ptw_walker u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_lin(req_lin), .req_write(req_write), .req_user(req_user),
        .req_pg_en(req_pg_en), .cr3(cr3), .cr0_wp(cr0_wp), .cr4_pse(cr4_pse),
        .a20_mask(a20_mask), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .res_fault(res_fault),
        .res_ecode(res_ecode), .res_cr2(res_cr2), .res_paddr(res_paddr),
        .res_wr(res_wr), .res_big(res_big)
    );

    typedef struct packed {
        logic             fault;
        logic [2:0]       ecode;
        logic [31:0]      cr2;
        logic [31:0]      paddr;
        logic             wr;
        logic             big;
        logic [2:0]       nacc;
        logic [3:0][64:0] tr;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];
    logic [31:0] mem [logic [29:0]];
    logic [3:0][64:0] log_tr;
    int log_n = 0;
    int mem_lat = 0;
    int n_chk = 0;
    int n_fail = 0;
    int n_done = 0;
    int n_walk = 0;

    function automatic logic [31:0] rd(logic [31:0] a);
        return mem.exists(a[31:2]) ? mem[a[31:2]] : 32'd0;
    endfunction

    task automatic setw(input logic [31:0] a, input logic [31:0] d);
        mem[a[31:2]] = d;
    endtask

    function automatic logic denied(logic us, logic rw, logic u, logic w, logic wp);
        if (u) return !us || (w && !rw);
        return wp && w && !rw;
    endfunction

    function automatic logic may_write(logic rw, logic u, logic wp);
        return u ? rw : (rw || !wp);
    endfunction

    task automatic model(input logic [31:0] lin, input logic w, input logic u,
                         input logic pg, output exp_t e);
        logic [31:0] pa, ta, pde, pte, nd, nt;
        int n;
        e = '0;
        e.cr2 = lin;
        n = 0;
        if (!pg) begin
            e.paddr = lin & 32'hFFFFF000 & a20_mask;
            e.wr = 1'b1;
        end else begin
            pa = ((cr3 & 32'hFFFFF000) + {20'd0, lin[31:22], 2'b00}) & a20_mask;
            pde = rd(pa);
            e.tr[n] = {1'b0, pa, 32'd0}; n++;
            if (!pde[0]) begin
                e.fault = 1'b1; e.ecode = {u, w, 1'b0};
            end else if (pde[7] && cr4_pse) begin
                if (denied(pde[2], pde[1], u, w, cr0_wp)) begin
                    e.fault = 1'b1; e.ecode = {u, w, 1'b1};
                end else begin
                    nd = pde | 32'h20 | (w ? 32'h40 : 32'h0);
                    if (nd != pde) begin e.tr[n] = {1'b1, pa, nd}; n++; end
                    e.paddr = ((pde & 32'hFFC00000) | (lin & 32'h003FF000)) & a20_mask;
                    e.wr = nd[6] && may_write(pde[1], u, cr0_wp);
                    e.big = 1'b1;
                end
            end else begin
                if (!pde[5]) begin e.tr[n] = {1'b1, pa, pde | 32'h20}; n++; end
                ta = ((pde & 32'hFFFFF000) + {20'd0, lin[21:12], 2'b00}) & a20_mask;
                pte = rd(ta);
                e.tr[n] = {1'b0, ta, 32'd0}; n++;
                if (!pte[0]) begin
                    e.fault = 1'b1; e.ecode = {u, w, 1'b0};
                end else if (denied(pde[2] & pte[2], pde[1] & pte[1], u, w, cr0_wp)) begin
                    e.fault = 1'b1; e.ecode = {u, w, 1'b1};
                end else begin
                    nt = pte | 32'h20 | (w ? 32'h40 : 32'h0);
                    if (nt != pte) begin e.tr[n] = {1'b1, ta, nt}; n++; end
                    e.paddr = pte & 32'hFFFFF000 & a20_mask;
                    e.wr = nt[6] && may_write(pde[1] & pte[1], u, cr0_wp);
                end
            end
        end
        e.nacc = 3'(n);
    endtask

    task automatic check32(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // memory responder: one access at a time, latency mem_lat idle cycles
    initial begin
        int wcnt;
        wcnt = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (!rst && mem_req) begin
                if (wcnt < mem_lat) begin
                    wcnt++;
                end else begin
                    wcnt = 0;
                    if (log_n < 4) log_tr[log_n] = {mem_we, mem_addr, mem_we ? mem_wdata : 32'd0};
                    log_n++;
                    if (mem_we) mem[mem_addr[31:2]] = mem_wdata;
                    else mem_rdata = rd(mem_addr);
                    mem_ack = 1'b1;
                end
            end
        end
    end

    // monitor: pops expected items on each done pulse
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && done) begin
                n_done++;
                n_chk++;
                if (expq.size() == 0) begin
                    n_fail++;
                    $display("FAIL R12: actual done without request, expected no done");
                end else begin
                    exp_t e;
                    string tg;
                    logic ok;
                    e = expq.pop_front();
                    tg = tagq.pop_front();
                    ok = (res_fault == e.fault) && (log_n == int'(e.nacc));
                    if (e.fault) ok = ok && (res_ecode == e.ecode) && (res_cr2 == e.cr2);
                    else ok = ok && (res_paddr == e.paddr) && (res_wr == e.wr) && (res_big == e.big);
                    for (int i = 0; i < 4; i++)
                        if (i < int'(e.nacc) && log_tr[i] !== e.tr[i]) ok = 1'b0;
                    if (!ok) begin
                        n_fail++;
                        $display("FAIL %s: actual fault=%0b code=%0h cr2=%h pa=%h wr=%0b big=%0b acc=%0d tr0=%h tr1=%h; expected fault=%0b code=%0h cr2=%h pa=%h wr=%0b big=%0b acc=%0d tr0=%h tr1=%h",
                                 tg, res_fault, res_ecode, res_cr2, res_paddr, res_wr, res_big, log_n,
                                 log_tr[0], log_tr[1], e.fault, e.ecode, e.cr2, e.paddr, e.wr, e.big,
                                 e.nacc, e.tr[0], e.tr[1]);
                    end
                end
                log_n = 0;
            end
        end
    end

    task automatic walk(input logic [31:0] lin, input logic w, input logic u, input logic pg,
                        input string tag, input int lat, input bit noisy);
        exp_t e;
        model(lin, w, u, pg, e);
        expq.push_back(e);
        tagq.push_back(tag);
        mem_lat = lat;
        n_walk++;
        @(negedge clk);
        req_valid = 1'b1; req_lin = lin; req_write = w; req_user = u; req_pg_en = pg;
        @(negedge clk);
        if (noisy) begin
            // R12: request held while busy must not start a walk
            req_lin = 32'h00800000; req_write = 1'b1; req_pg_en = 1'b0;
            repeat (3) @(negedge clk);
        end
        req_valid = 1'b0;
        while (expq.size() != 0) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual run still busy, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        cr3 = 32'h00010000; cr0_wp = 1'b0; cr4_pse = 1'b1; a20_mask = 32'hFFFFFFFF;
        setw(32'h00010004, 32'h00020007);
        setw(32'h0002000C, 32'h00555007);
        setw(32'h0001000C, 32'h00030023);
        setw(32'h00030000, 32'h00666067);
        setw(32'h00010010, 32'h00040025);
        setw(32'h00040000, 32'h00777067);
        setw(32'h00010014, 32'h01400087);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check32("R12 reset ready", {31'd0, req_ready}, 32'd1);
        check32("R12 reset done", {31'd0, done}, 32'd0);
        check32("R12 reset mem_req", {31'd0, mem_req}, 32'd0);

        walk(32'h12345678, 1'b0, 1'b1, 1'b0, "R1 paging off", 0, 1'b0);
        a20_mask = 32'hFFEFFFFF;
        walk(32'h00178ABC, 1'b1, 1'b0, 1'b0, "R1 R11 paging off a20", 1, 1'b0);
        a20_mask = 32'hFFFFFFFF;

        walk(32'h00403123, 1'b0, 1'b1, 1'b1, "R2 R3 R8 first read", 1, 1'b0);
        check32("R8 dir accessed", rd(32'h00010004), 32'h00020027);
        check32("R8 table accessed", rd(32'h0002000C), 32'h00555027);
        walk(32'h00403123, 1'b0, 1'b1, 1'b1, "R8 R10 no rewrite clean read", 2, 1'b0);
        walk(32'h00403123, 1'b1, 1'b1, 1'b1, "R9 R10 dirty on write", 0, 1'b0);
        check32("R9 table dirty", rd(32'h0002000C), 32'h00555067);
        walk(32'h00403123, 1'b1, 1'b1, 1'b1, "R10 dirty leaf writable", 3, 1'b0);

        walk(32'h00800000, 1'b1, 1'b1, 1'b1, "R5 R7 absent directory", 1, 1'b0);
        walk(32'h00405000, 1'b0, 1'b0, 1'b1, "R5 absent table", 0, 1'b0);

        walk(32'h00C00000, 1'b0, 1'b1, 1'b1, "R6 R7 user needs user bit", 2, 1'b0);
        walk(32'h00C00000, 1'b1, 1'b0, 1'b1, "R6 supervisor write", 0, 1'b0);
        walk(32'h01000000, 1'b1, 1'b1, 1'b1, "R6 R7 user write and-ed rw", 1, 1'b0);
        walk(32'h01000000, 1'b1, 1'b0, 1'b1, "R6 supervisor write wp0", 0, 1'b0);
        cr0_wp = 1'b1;
        walk(32'h01000000, 1'b1, 1'b0, 1'b1, "R6 supervisor write wp1", 1, 1'b0);
        walk(32'h01000000, 1'b0, 1'b0, 1'b1, "R10 wp1 read not writable", 0, 1'b0);
        cr0_wp = 1'b0;

        walk(32'h01523456, 1'b0, 1'b0, 1'b1, "R4 large page read", 2, 1'b0);
        check32("R8 large dir accessed", rd(32'h00010014), 32'h014000A7);
        walk(32'h01523456, 1'b1, 1'b1, 1'b1, "R4 R9 large page write", 0, 1'b0);
        check32("R9 large dir dirty", rd(32'h00010014), 32'h014000E7);
        cr4_pse = 1'b0;
        walk(32'h01523456, 1'b0, 1'b1, 1'b1, "R4 size bit ignored without enable", 1, 1'b0);
        cr4_pse = 1'b1;

        cr3 = 32'h00110000; a20_mask = 32'hFFEFFFFF;
        walk(32'h00403123, 1'b0, 1'b0, 1'b1, "R2 R11 masked walk", 1, 1'b0);
        cr3 = 32'h00010000; a20_mask = 32'hFFFFFFFF;

        walk(32'h00403123, 1'b0, 1'b1, 1'b1, "R12 busy request ignored", 3, 1'b1);
        repeat (20) @(negedge clk);
        check32("R12 one done per request", n_done, n_walk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule